// File: doc/BRIEF.md
# I2C Slave Transmitter with Register Flag Handshake

This block is the target side of an I2C bus. It watches the bus for a start condition. It then compares the first byte that follows against a 7-bit address held in a register. On a match it answers in the ninth clock with a level that software chooses. If the direction bit of that byte asks for a read, the block enters transmit mode by itself and raises its transmit-empty flag. No software action is needed for that switch.

Software keeps the transfer going through a small register file. Each time the empty flag shows, it writes the next byte. The block moves each byte from the holding register into its shifter and sends it most significant bit first under the master's clock. When the shifter needs a byte and none is waiting, the block holds SCL low. After a byte that the master acknowledged, with nothing left to send, the block raises a transmit-end flag and keeps SCL low. The bus is freed only when software clears transmit mode and then reads the receive register once.

For write transfers, and for the address byte itself, a receive register with a full flag captures each byte. Both bus lines are open drain: the outputs are pull-low enables.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, the control register (offset 0: bit 0 enable, bit 1 transmit mode, bit 2 acknowledge level) and the status register (offset 2: bit 0 transmit empty, bit 1 transmit end, bit 2 receive full) read 0, and neither line is pulled low.
- R2: While enable is 0 the block acknowledges no address. Writing enable to 0 during a transfer releases SCL and SDA on the next cycle and clears every status flag and the transmit-mode bit.
- R3: Only the first byte after a start is compared. When its upper seven bits equal the own address (offset 1, bits 6:0), SDA is driven during the ninth clock. A byte with a different address gets no response.
- R4: The level driven in the ninth clock is the acknowledge-level bit: 0 pulls SDA low (acknowledge), and 1 leaves it high.
- R5: When a matching address byte has direction bit 1, the transmit-mode bit and the transmit-empty flag are set without any register write. With direction bit 0, transmit mode stays clear.
- R6: Transmit bytes appear on SDA bit 7 first, one bit per clock over clocks 1 to 8, in the order software wrote them.
- R7: Writing the transmit register (offset 3) clears transmit-empty. The flag sets again once the byte has moved into the shifter.
- R8: When a byte must start and the transmit register is empty, SCL is held low until software writes a byte.
- R9: When the master acknowledges a byte and the transmit register is empty, transmit-end is set. Writing 1 to status bit 1, or writing a new byte, clears it.
- R10: After the final byte, SCL stays low even once transmit mode is cleared. It is released only when the receive register (offset 4) is read while transmit mode is 0.
- R11: A not-acknowledge from the master in the ninth clock ends the transmission. SDA and SCL stay released until the next start or stop.
- R12: A stop condition returns the block to idle with transmit mode cleared, and the next start is again compared with the own address.
- R13: The matching address byte and every byte of a write transfer are stored in the receive register with receive-full set. A read of offset 4 clears receive-full.
- R14: SDA is never changed by the block while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level as seen on the bus |
| sda_in | input | 1 | SDA line level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from offset |

## Verification
The transmit path is driven with the bytes A5, 3C, FF and 00. These tell apart bit order, stuck bits and missing edge bits. Address bytes are tried matching with direction read and write, not matching, with the block disabled and with acknowledge level 1. Each of these separates the compare from the acknowledge drive and from the automatic mode switch. The end of a read is tried three ways: a master acknowledge into an empty buffer, which must stretch until software clears transmit mode and does a dummy read; a master not-acknowledge, which must release everything; and a disable in the middle of a stretch. A per-clock monitor watches for SDA moving while SCL is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int REG_AW   = 3;
    localparam int BIT_CNT_W = $clog2(DATA_W + 1);

    // register offsets
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] OFS_OWN  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd2;
    localparam logic [REG_AW-1:0] OFS_TX   = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RX   = 3'd4;

    // control bits
    localparam int CB_EN   = 0;
    localparam int CB_XMIT = 1;
    localparam int CB_ACKL = 2;

    // status bits
    localparam int SB_TXE  = 0;
    localparam int SB_TEND = 1;
    localparam int SB_RXF  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_OUT,
        ST_RX,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD,
        ST_WAIT
    } eng_state_t;

    typedef struct packed {
        logic set_xmit;
        logic load;
        logic tx_end;
        logic rx_store;
        logic stop;
    } eng_ev_t;

    function automatic logic addr_hit(input logic [DATA_W-1:0] frame,
                                      input logic [ADDR_W-1:0] own);
        return frame[DATA_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_d, sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [REG_AW-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  eng_ev_t               ev,
    input  logic [DATA_W-1:0]     rx_byte,
    output logic                  enable,
    output logic                  xmit,
    output logic                  ack_level,
    output logic [ADDR_W-1:0]     own_addr,
    output logic [DATA_W-1:0]     txbuf,
    output logic                  tx_empty,
    output logic                  rx_read
);
    logic                tx_end;
    logic                rx_full;
    logic [DATA_W-1:0]   rxbuf;
    logic                tx_wr;

    assign tx_wr   = wr && (addr == OFS_TX);
    assign rx_read = rd && (addr == OFS_RX);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable    <= 1'b0;
            xmit      <= 1'b0;
            ack_level <= 1'b0;
            own_addr  <= '0;
            txbuf     <= '0;
            tx_empty  <= 1'b0;
            tx_end    <= 1'b0;
            rx_full   <= 1'b0;
            rxbuf     <= '0;
        end else begin
            if (wr && addr == OFS_CTRL) begin
                enable    <= wdata[CB_EN];
                xmit      <= wdata[CB_XMIT];
                ack_level <= wdata[CB_ACKL];
            end
            if (wr && addr == OFS_OWN)
                own_addr <= wdata[ADDR_W-1:0];
            if (ev.set_xmit) begin
                xmit     <= 1'b1;
                tx_empty <= 1'b1;
            end
            if (ev.stop)
                xmit <= 1'b0;
            if (ev.load)
                tx_empty <= 1'b1;
            if (ev.tx_end && tx_empty)
                tx_end <= 1'b1;
            if (rx_read)
                rx_full <= 1'b0;
            if (ev.rx_store) begin
                rxbuf   <= rx_byte;
                rx_full <= 1'b1;
            end
            if (wr && addr == OFS_STAT && wdata[SB_TEND])
                tx_end <= 1'b0;
            if (tx_wr) begin
                txbuf    <= wdata;
                tx_empty <= 1'b0;
                tx_end   <= 1'b0;
            end
            if (!enable) begin
                xmit     <= 1'b0;
                tx_empty <= 1'b0;
                tx_end   <= 1'b0;
                rx_full  <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CB_EN]   = enable;
                rdata[CB_XMIT] = xmit;
                rdata[CB_ACKL] = ack_level;
            end
            OFS_OWN:  rdata[ADDR_W-1:0] = own_addr;
            OFS_STAT: begin
                rdata[SB_TXE]  = tx_empty;
                rdata[SB_TEND] = tx_end;
                rdata[SB_RXF]  = rx_full;
            end
            OFS_TX:   rdata = txbuf;
            OFS_RX:   rdata = rxbuf;
            default:  rdata = '0;
        endcase
    end

    // R9: transmit-end only ever shows with an empty transmit register
    a_r9_end_needs_empty: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> tx_empty);

    // R7: a write to the transmit register leaves it full on the next cycle
    a_r7_write_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && enable) |=> !tx_empty);

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_s,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_ev,
    input  logic                  stop_ev,
    input  logic                  enable,
    input  logic                  ack_level,
    input  logic                  xmit,
    input  logic [ADDR_W-1:0]     own_addr,
    input  logic [DATA_W-1:0]     txbuf,
    input  logic                  tx_empty,
    input  logic                  rx_read,
    output eng_ev_t               ev,
    output logic [DATA_W-1:0]     rx_byte,
    output logic                  sda_oe,
    output logic                  scl_oe
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W);

    eng_state_t           state;
    logic [BIT_CNT_W-1:0] cnt;
    logic [DATA_W-1:0]    shreg;
    logic                 rw;
    logic                 is_addr;

    always_ff @(posedge clk) begin
        ev <= '0;
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            is_addr <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
        end else if (!enable) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            ev.stop <= 1'b1;
        end else if (start_ev) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST_BIT) begin
                        if (addr_hit(shreg, own_addr)) begin
                            rw          <= shreg[0];
                            rx_byte     <= shreg;
                            ev.rx_store <= 1'b1;
                            sda_oe      <= ~ack_level;
                            is_addr     <= 1'b1;
                            cnt         <= '0;
                            state       <= ST_ACK_OUT;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_rise && is_addr && rw)
                        ev.set_xmit <= 1'b1;
                    else if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= (is_addr && rw) ? ST_HOLD : ST_RX;
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST_BIT) begin
                        rx_byte     <= shreg;
                        ev.rx_store <= 1'b1;
                        sda_oe      <= ~ack_level;
                        is_addr     <= 1'b0;
                        state       <= ST_ACK_OUT;
                    end
                end
                ST_HOLD: begin
                    if (!tx_empty) begin
                        shreg   <= txbuf;
                        sda_oe  <= ~txbuf[DATA_W-1];
                        ev.load <= 1'b1;
                        cnt     <= '0;
                        state   <= ST_TX;
                    end else if (rx_read && !xmit) begin
                        state <= ST_WAIT;
                    end
                end
                ST_TX: begin
                    if (scl_rise)
                        cnt <= cnt + 1'b1;
                    else if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~shreg[DATA_W-2];
                            shreg  <= shreg << 1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s)
                            state <= ST_WAIT;
                        else if (tx_empty)
                            ev.tx_end <= 1'b1;
                    end else if (scl_fall) begin
                        state <= ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    assign scl_oe = enable && (state == ST_HOLD);

    // R14: the block only starts pulling SDA while SCL is low
    a_r14_pull_with_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R8: a stretch ends on the cycle after the transmit register fills
    a_r8_stretch_ends_on_data: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && !tx_empty) |=> !scl_oe);

    // R11: a master not-acknowledge leaves SDA released
    a_r11_nack_releases: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK && scl_rise && sda_s && enable && !start_ev && !stop_ev)
        |=> (!sda_oe && state == ST_WAIT));

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic enable, xmit, ack_level, tx_empty, rx_read;
    logic [ADDR_W-1:0] own_addr;
    logic [DATA_W-1:0] txbuf, rx_byte;
    eng_ev_t ev;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ev        (ev),
        .rx_byte   (rx_byte),
        .enable    (enable),
        .xmit      (xmit),
        .ack_level (ack_level),
        .own_addr  (own_addr),
        .txbuf     (txbuf),
        .tx_empty  (tx_empty),
        .rx_read   (rx_read)
    );

    i2cs_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .enable    (enable),
        .ack_level (ack_level),
        .xmit      (xmit),
        .own_addr  (own_addr),
        .txbuf     (txbuf),
        .tx_empty  (tx_empty),
        .rx_read   (rx_read),
        .ev        (ev),
        .rx_byte   (rx_byte),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    // R2: with the interface disabled both lines are released
    a_r2_off_releases: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sda_oe && !scl_oe));

endmodule

// File: tb/i2c_slave_tx_bench.sv
module i2c_slave_tx_bench;

    localparam int H = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic scl_oe, sda_oe;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int mon_err = 0;
    bit done = 1'b0;
    logic [7:0] tx_q[$];

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_slave_tx u_i2c_slave_tx (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // per-clock protocol model: the slave must not move SDA while SCL is high (R14)
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (!rst && prev_scl && scl_line && (sda_oe != prev_oe))
            mon_err++;
        prev_scl = scl_line;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rw_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic scl_up();
        int n = 0;
        m_scl = 1'b1;
        while (!scl_line && n < 20000) begin
            tick(1);
            n++;
        end
    endtask

    task automatic wr_bit(input logic b);
        tick(4); m_sda = b; tick(H - 4);
        scl_up(); tick(H);
        m_scl = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        tick(4); m_sda = 1'b1; tick(H - 4);
        scl_up(); tick(H / 2);
        b = sda_line;
        tick(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic m_start();
        m_sda = 1'b1; tick(H);
        scl_up(); tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic m_stop();
        tick(4); m_sda = 1'b0; tick(H);
        scl_up(); tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) wr_bit(b[i]);
        rd_bit(x);
        acked = !x;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(x);
            b[i] = x;
        end
        wr_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic tx_push(input logic [7:0] b);
        logic [7:0] st;
        int n = 0;
        st = 8'h00;
        while (!st[0] && n < 2000) begin
            rd_reg(3'd2, st);
            n++;
        end
        rw_reg(3'd3, b);
        tx_q.push_back(b);
    endtask

    task automatic expect_byte(input logic give_ack);
        logic [7:0] got, exp;
        recv_byte(got, give_ack);
        exp = tx_q.pop_front();
        chk("R6 transmitted byte", int'(got), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic ack;
        tick(5);
        rst = 1'b0;
        tick(3);

        // R1 reset state
        rd_reg(3'd0, d); chk("R1 control after reset", int'(d), 0);
        rd_reg(3'd2, d); chk("R1 status after reset", int'(d), 0);
        chk("R1 lines released", int'({scl_oe, sda_oe}), 0);

        // R2 disabled: no acknowledge
        rw_reg(3'd1, 8'h2A);
        m_start(); send_byte(8'h55, ack); m_stop();
        chk("R2 disabled gives no ack", int'(ack), 0);

        rw_reg(3'd0, 8'h01);

        // R3 mismatching address
        m_start(); send_byte(8'h56, ack); m_stop();
        chk("R3 other address not acked", int'(ack), 0);

        // R3/R13/R5 write transfer
        m_start(); send_byte(8'h54, ack);
        chk("R3 own address acked", int'(ack), 1);
        rd_reg(3'd2, d); chk("R13 receive full after address", int'(d), 8'h04);
        rd_reg(3'd4, d); chk("R13 address byte stored", int'(d), 8'h54);
        rd_reg(3'd2, d); chk("R13 receive full cleared by read", int'(d), 8'h00);
        send_byte(8'hC3, ack);
        chk("R3 data byte acked", int'(ack), 1);
        rd_reg(3'd4, d); chk("R13 data byte stored", int'(d), 8'hC3);
        rd_reg(3'd0, d); chk("R5 write keeps receive mode", int'(d), 8'h01);
        m_stop();

        // R4 acknowledge level 1
        rw_reg(3'd0, 8'h05);
        m_start(); send_byte(8'h54, ack); m_stop();
        chk("R4 level 1 leaves SDA high", int'(ack), 0);
        rw_reg(3'd0, 8'h01);

        // read transfer with stretching, end flag and release
        m_start(); send_byte(8'h55, ack);
        chk("R3 read address acked", int'(ack), 1);
        tick(4);
        rd_reg(3'd0, d); chk("R5 transmit mode set itself", int'(d), 8'h03);
        rd_reg(3'd2, d); chk("R5 transmit empty set itself", int'(d[0]), 1);
        m_scl = 1'b1; tick(40);
        chk("R8 SCL stretched with no data", int'(scl_line), 0);
        m_scl = 1'b0; tick(4);
        tx_push(8'hA5);
        tick(6);
        rd_reg(3'd2, d); chk("R7 empty again after move to shifter", int'(d[0]), 1);
        tx_push(8'h3C);
        rd_reg(3'd2, d); chk("R7 write clears empty", int'(d[0]), 0);
        expect_byte(1'b1);
        tx_push(8'hFF);
        expect_byte(1'b1);
        tx_push(8'h00);
        expect_byte(1'b1);
        expect_byte(1'b1);
        tick(4);
        rd_reg(3'd2, d); chk("R9 transmit end set", int'(d[1]), 1);
        m_scl = 1'b1; tick(30);
        chk("R8 SCL held after last byte", int'(scl_line), 0);
        m_scl = 1'b0; tick(4);
        rw_reg(3'd2, 8'h02);
        rd_reg(3'd2, d); chk("R9 transmit end cleared by write", int'(d[1]), 0);
        rw_reg(3'd0, 8'h01);
        tick(10);
        chk("R10 still held after mode clear", int'(scl_oe), 1);
        rd_reg(3'd4, d);
        tick(4);
        chk("R10 released after dummy read", int'(scl_oe), 0);
        m_stop();

        // R11 not-acknowledge, R12 stop
        m_start(); send_byte(8'h55, ack);
        tx_push(8'h96);
        tx_push(8'h11);
        expect_byte(1'b0);
        void'(tx_q.pop_front());
        tick(40);
        chk("R11 SDA released after nack", int'(sda_oe), 0);
        chk("R11 SCL released after nack", int'(scl_oe), 0);
        rd_reg(3'd0, d); chk("R12 mode held until stop", int'(d), 8'h03);
        m_stop();
        rd_reg(3'd0, d); chk("R12 stop clears transmit mode", int'(d), 8'h01);
        m_start(); send_byte(8'h54, ack);
        chk("R12 address compared after stop", int'(ack), 1);
        send_byte(8'h7E, ack);
        rd_reg(3'd4, d); chk("R13 second write byte", int'(d), 8'h7E);
        m_stop();

        // R2 disable during a stretch
        m_start(); send_byte(8'h55, ack);
        tick(4);
        chk("R8 stretching before disable", int'(scl_oe), 1);
        rw_reg(3'd0, 8'h00);
        tick(3);
        chk("R2 disable releases lines", int'({scl_oe, sda_oe}), 0);
        rd_reg(3'd2, d); chk("R2 disable clears flags", int'(d), 0);
        rd_reg(3'd0, d); chk("R2 disable clears transmit mode", int'(d), 0);
        m_stop();

        chk("R14 SDA steady while SCL high", mon_err, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule